// File: doc/BRIEF.md
# Halfword Instruction Joiner for a Compact 16-bit Encoding

This block sits behind an instruction fetch unit that delivers 16-bit halfwords of a compressed instruction set. Most instructions fit in one halfword. Two kinds take two halfwords: a prefix halfword, which widens the immediate of the instruction that follows it, and a long jump, which spreads a 26-bit target across both halfwords. The joiner takes halfwords through a valid/ready handshake. When it sees the first half of a two-halfword instruction, it holds it until the partner arrives, then emits one decoded record.

Each record gives the instruction size, the major opcode, a format class, the immediate rebuilt into contiguous bit order and zero-extended, and the raw combined word. The bits of the immediate are scattered across the two halfwords, and the order depends on the format. The joiner undoes the shuffle for five layouts: general, two-register-with-function, shift, frame save/restore, and jump. A prefix followed by a second prefix or by a jump halfword is reported as an illegal record, and the joiner goes back to idle.

Top module: `xinsn_joiner`

## Requirements
- R1: During and after a synchronous reset, `out_valid` is low and no first halfword is pending. `in_ready` is high once reset is released.
- R2: A halfword whose bits 15:11 are neither 11110 (prefix) nor 00011 (jump) is taken as a plain instruction. It appears on the outputs one cycle after it is accepted, with the following values:
  - `out_wide`=0 and `out_major`=bits 15:11.
  - `out_word`={16'h0, halfword} and `out_imm`=0.
  - `out_class`=0.
  - Class codes: 0 plain, 1 prefixed general, 2 prefixed two-register-with-function, 3 prefixed shift, 4 prefixed frame, 5 jump, 6 illegal, 7 short frame.
- R3: A prefix halfword produces no output while it waits, and `in_ready` stays high during the wait. The following halfword completes a record with `out_wide`=1, `out_word`={prefix, second}, and `out_major`=second halfword bits 15:11.
- R4: Prefixed general class (1) applies when the second opcode is none of 01000, 00110, or 01100 with bits 10:8=100. In this class the immediate is {word[20:16], word[26:21], word[4:0]}.
- R5: Second opcode 01000 gives class 2. Its 15-bit immediate is {word[19:16], word[26:20], word[3:0]}.
- R6: Second opcode 00110 gives class 3. Its 6-bit shift amount is {word[21], word[26:22]}.
- R7: Second opcode 01100 with bits 10:8=100 gives class 4. Its 8-bit frame size is {word[23:20], word[3:0]}.
- R8: A single halfword with opcode 01100 and bits 10:8=100 is class 7. Its immediate is bits 3:0.
- R9: A first halfword with opcode 00011 is paired with the next halfword of any value. The record has class 5, major 00011, word bit 26 as the exchange flag, and target {word[20:16], word[25:21], word[15:0]}.
- R10: A pending prefix followed by a halfword with opcode 11110 or 00011 yields an illegal record. That record has class 6, `out_wide`=1, the combined word, the second halfword's opcode as major, and immediate 0. The joiner then returns to idle.
- R11: While `out_valid` is high and `out_ready` is low, all outputs hold and `in_ready` is low.
- R12: A reset while a prefix is pending discards it. The next halfword is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword can be taken |
| in_half | input | 16 | Instruction halfword |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_wide | output | 1 | 1 for a four-byte instruction, 0 for two bytes |
| out_major | output | 5 | Major opcode |
| out_class | output | 3 | Format class code |
| out_imm | output | IMM_W | Rebuilt immediate, zero-extended |
| out_word | output | 32 | Raw combined word |

## Verification
The bench builds the joiner with `IMM_W`=26 and `JUMP_EN`=1. That configuration exposes all 26 jump target bits, and the jump opcode counts both as a pair opener and as the illegal follower of a prefix. Immediates are chosen with distinct bits in every field, so a swapped or shifted slice shows up as a wrong value. Back-pressure and a reset in the middle of a pending pair are driven as separate phases.

// File: rtl/xj_pkg.sv
package xj_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;
   localparam int OPC_W  = 5;
   localparam int TGT_W  = 26;

   localparam logic [OPC_W-1:0] OPC_PREFIX = 5'b11110;
   localparam logic [OPC_W-1:0] OPC_JUMP   = 5'b00011;
   localparam logic [OPC_W-1:0] OPC_RRIA   = 5'b01000;
   localparam logic [OPC_W-1:0] OPC_SHIFT  = 5'b00110;
   localparam logic [OPC_W-1:0] OPC_I8     = 5'b01100;
   localparam logic [2:0]       I8_FRAME   = 3'b100;

   typedef enum logic [2:0] {
      CL_PLAIN   = 3'd0,
      CL_XGEN    = 3'd1,
      CL_XRRIA   = 3'd2,
      CL_XSHIFT  = 3'd3,
      CL_XFRAME  = 3'd4,
      CL_JUMP    = 3'd5,
      CL_BAD     = 3'd6,
      CL_FRAME16 = 3'd7
   } cls_t;
endpackage

// File: rtl/xj_classify.sv
module xj_classify
   import xj_pkg::*;
(
   input  logic              pend,
   input  logic              pend_jmp,
   input  logic [HALF_W-1:0] first,
   input  logic [HALF_W-1:0] cur,
   input  logic              cur_pfx,
   input  logic              cur_jmp,
   output cls_t              cls,
   output logic [OPC_W-1:0]  major,
   output logic [WORD_W-1:0] word,
   output logic              wide
);
   logic [OPC_W-1:0] cur_op;
   logic             cur_frame;

   assign cur_op    = cur[HALF_W-1 -: OPC_W];
   assign cur_frame = (cur_op == OPC_I8) && (cur[10:8] == I8_FRAME);

   always_comb begin
      if (!pend) begin
         word  = {{HALF_W{1'b0}}, cur};
         wide  = 1'b0;
         major = cur_op;
         cls   = cur_frame ? CL_FRAME16 : CL_PLAIN;
      end else if (pend_jmp) begin
         word  = {first, cur};
         wide  = 1'b1;
         major = OPC_JUMP;
         cls   = CL_JUMP;
      end else begin
         word  = {first, cur};
         wide  = 1'b1;
         major = cur_op;
         if (cur_pfx || cur_jmp)        cls = CL_BAD;
         else if (cur_op == OPC_RRIA)   cls = CL_XRRIA;
         else if (cur_op == OPC_SHIFT)  cls = CL_XSHIFT;
         else if (cur_frame)            cls = CL_XFRAME;
         else                           cls = CL_XGEN;
      end
   end
endmodule

// File: rtl/xj_imm_unpack.sv
module xj_imm_unpack
   import xj_pkg::*;
#(
   parameter int IMM_W = 26
)(
   input  cls_t              cls,
   input  logic [WORD_W-1:0] word,
   output logic [IMM_W-1:0]  imm
);
   always_comb begin
      imm = '0;
      case (cls)
         CL_XGEN:    imm[15:0]      = {word[20:16], word[26:21], word[4:0]};
         CL_XRRIA:   imm[14:0]      = {word[19:16], word[26:20], word[3:0]};
         CL_XSHIFT:  imm[5:0]       = {word[21], word[26:22]};
         CL_XFRAME:  imm[7:0]       = {word[23:20], word[3:0]};
         CL_FRAME16: imm[3:0]       = word[3:0];
         CL_JUMP:    imm[TGT_W-1:0] = {word[20:16], word[25:21], word[15:0]};
         default:    imm            = '0;
      endcase
   end
endmodule

// File: rtl/xinsn_joiner.sv
module xinsn_joiner
   import xj_pkg::*;
#(
   parameter int IMM_W   = 26,
   parameter bit JUMP_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [15:0]      in_half,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_wide,
   output logic [4:0]       out_major,
   output logic [2:0]       out_class,
   output logic [IMM_W-1:0] out_imm,
   output logic [31:0]      out_word
);
   generate
      if (IMM_W < TGT_W) begin : g_imm_too_narrow
         $error("IMM_W must hold the full jump target");
      end
   endgenerate

   logic              pend_q;
   logic              pend_jmp_q;
   logic [HALF_W-1:0] pend_half_q;
   logic              take;
   logic              cur_pfx;
   logic              cur_jmp;
   logic              opens;
   logic              emit;

   cls_t              c_cls;
   logic [OPC_W-1:0]  c_major;
   logic [WORD_W-1:0] c_word;
   logic              c_wide;
   logic [IMM_W-1:0]  c_imm;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;
   assign cur_pfx  = (in_half[HALF_W-1 -: OPC_W] == OPC_PREFIX);

   generate
      if (JUMP_EN) begin : g_jump
         assign cur_jmp = (in_half[HALF_W-1 -: OPC_W] == OPC_JUMP);
      end else begin : g_no_jump
         assign cur_jmp = 1'b0;
      end
   endgenerate

   assign opens = !pend_q && (cur_pfx || cur_jmp);
   assign emit  = take && !opens;

   xj_classify u_classify (
      .pend     (pend_q),
      .pend_jmp (pend_jmp_q),
      .first    (pend_half_q),
      .cur      (in_half),
      .cur_pfx  (cur_pfx),
      .cur_jmp  (cur_jmp),
      .cls      (c_cls),
      .major    (c_major),
      .word     (c_word),
      .wide     (c_wide)
   );

   xj_imm_unpack #(.IMM_W(IMM_W)) u_unpack (
      .cls  (c_cls),
      .word (c_word),
      .imm  (c_imm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q      <= 1'b0;
         pend_jmp_q  <= 1'b0;
         pend_half_q <= '0;
         out_valid   <= 1'b0;
         out_wide    <= 1'b0;
         out_major   <= '0;
         out_class   <= '0;
         out_imm     <= '0;
         out_word    <= '0;
      end else begin
         if (take) begin
            if (opens) begin
               pend_q      <= 1'b1;
               pend_jmp_q  <= cur_jmp;
               pend_half_q <= in_half;
            end else begin
               pend_q      <= 1'b0;
               pend_jmp_q  <= 1'b0;
            end
         end
         if (emit) begin
            out_valid <= 1'b1;
            out_wide  <= c_wide;
            out_major <= c_major;
            out_class <= c_cls;
            out_imm   <= c_imm;
            out_word  <= c_word;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xj_chk.sv
module xj_chk #(
   parameter int IMM_W = 26
)(
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic [15:0]      in_half,
   input logic             out_valid,
   input logic             out_ready,
   input logic             out_wide,
   input logic [4:0]       out_major,
   input logic [2:0]       out_class,
   input logic [IMM_W-1:0] out_imm,
   input logic [31:0]      out_word,
   input logic             pend_q
);
   assert_reset_R1: assert property (@(posedge clk)
      rst |=> !out_valid && !pend_q);

   assert_short_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_class == 3'd0 || out_class == 3'd7)
      |-> !out_wide && out_word[31:16] == 16'h0);

   assert_wait_R3: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && !pend_q && in_half[15:11] == 5'b11110
      |=> pend_q && (out_valid == ($past(out_valid) && !$past(out_ready))));

   assert_shift_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_class == 3'd3
      |-> out_imm[IMM_W-1:6] == '0 && out_major == 5'b00110);

   assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_class == 3'd5
      |-> out_word[31:27] == 5'b00011 && out_major == 5'b00011 && out_wide);

   assert_bad_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_class == 3'd6
      |-> out_word[31:27] == 5'b11110 && out_imm == '0
          && (out_word[15:11] == 5'b11110 || out_word[15:11] == 5'b00011));

   assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready
      |=> out_valid && $stable(out_word) && $stable(out_class)
          && $stable(out_imm) && $stable(out_major) && $stable(out_wide));
endmodule

bind xinsn_joiner xj_chk #(.IMM_W(IMM_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_half   (in_half),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_wide  (out_wide),
   .out_major (out_major),
   .out_class (out_class),
   .out_imm   (out_imm),
   .out_word  (out_word),
   .pend_q    (pend_q)
);

// File: tb/tb_xinsn_joiner.sv
`timescale 1ns/1ps
module tb_xinsn_joiner;
   localparam int IMM_W = 26;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [15:0]      in_half = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic             out_wide;
   logic [4:0]       out_major;
   logic [2:0]       out_class;
   logic [IMM_W-1:0] out_imm;
   logic [31:0]      out_word;

   always #2 clk = ~clk;

   xinsn_joiner #(.IMM_W(IMM_W), .JUMP_EN(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_half(in_half), .out_valid(out_valid), .out_ready(out_ready),
      .out_wide(out_wide), .out_major(out_major), .out_class(out_class),
      .out_imm(out_imm), .out_word(out_word)
   );

   typedef struct packed {
      logic        wide;
      logic [4:0]  major;
      logic [2:0]  cls;
      logic [25:0] imm;
      logic [31:0] word;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_rec(input logic wide, input logic [4:0] major,
                             input logic [2:0] cls, input logic [25:0] imm,
                             input logic [31:0] word, input string tag);
      exp_t e;
      e.wide = wide; e.major = major; e.cls = cls; e.imm = imm; e.word = word;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic put_half(input logic [15:0] h);
      @(negedge clk);
      in_valid = 1'b1;
      in_half  = h;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
   endtask

   // Monitor: pops one expected record per completed output transfer
   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected record", {32'h0, out_word}, 64'h0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_wide, out_major, out_class, out_imm, out_word} === e, t,
                  {out_imm, 6'h0, out_class, out_wide, out_word[31:4]},
                  {e.imm, 6'h0, e.cls, e.wide, e.word[31:4]});
            check(out_word === e.word, {t, " word"}, {32'h0, out_word}, {32'h0, e.word});
         end
      end
   end

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", 64'h0, 64'h1);
         finish_run();
      end
   end

   initial begin
      logic [15:0] v16, p, s;
      logic [14:0] v15;
      logic [5:0]  sa;
      logic [7:0]  fs;
      logic [25:0] tg;

      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R1 out_valid in reset", {63'h0, out_valid}, 64'h0);
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      check(out_valid === 1'b0, "R1 out_valid after reset", {63'h0, out_valid}, 64'h0);
      check(in_ready === 1'b1, "R1 in_ready after reset", {63'h0, in_ready}, 64'h1);

      // R2 plain halfwords
      expect_rec(1'b0, 5'b01001, 3'd0, 26'h0, 32'h0000_4A23, "R2 plain a");
      put_half(16'h4A23);
      expect_rec(1'b0, 5'b11101, 3'd0, 26'h0, 32'h0000_E8A5, "R2 plain b");
      put_half(16'hE8A5);
      expect_rec(1'b0, 5'b01100, 3'd0, 26'h0, 32'h0000_6312, "R2 i8 non-frame");
      put_half(16'h6312);

      // R8 short frame
      s = {5'b01100, 3'b100, 4'b1010, 4'hB};
      expect_rec(1'b0, 5'b01100, 3'd7, 26'hB, {16'h0, s}, "R8 short frame");
      put_half(s);

      // R3 pending prefix, then R4 general immediate
      drain();
      v16 = 16'hA5C3;
      p = {5'b11110, v16[10:5], v16[15:11]};
      s = {5'b01001, 3'b010, 3'b000, v16[4:0]};
      put_half(p);
      check(out_valid === 1'b0, "R3 no output while pending", {63'h0, out_valid}, 64'h0);
      check(in_ready === 1'b1, "R3 ready while pending", {63'h0, in_ready}, 64'h1);
      repeat (2) @(negedge clk);
      check(out_valid === 1'b0, "R3 still silent", {63'h0, out_valid}, 64'h0);
      expect_rec(1'b1, 5'b01001, 3'd1, {10'h0, v16}, {p, s}, "R4 general imm");
      put_half(s);

      // R4 prefixed i8 with a non-frame sub-function stays general
      v16 = 16'h3E1D;
      p = {5'b11110, v16[10:5], v16[15:11]};
      s = {5'b01100, 3'b011, 3'b000, v16[4:0]};
      expect_rec(1'b1, 5'b01100, 3'd1, {10'h0, v16}, {p, s}, "R4 i8 general");
      put_half(p); put_half(s);

      // R5 two-register-with-function
      v15 = 15'h5A3C;
      p = {5'b11110, v15[10:4], v15[14:11]};
      s = {5'b01000, 3'b101, 3'b010, 1'b1, v15[3:0]};
      expect_rec(1'b1, 5'b01000, 3'd2, {11'h0, v15}, {p, s}, "R5 rria imm");
      put_half(p); put_half(s);

      // R6 shift amount
      sa = 6'h2D;
      p = {5'b11110, sa[4:0], sa[5], 5'b00000};
      s = {5'b00110, 3'b011, 3'b110, 3'b000, 2'b11};
      expect_rec(1'b1, 5'b00110, 3'd3, {20'h0, sa}, {p, s}, "R6 shift amount");
      put_half(p); put_half(s);

      // R7 prefixed frame
      fs = 8'hC7;
      p = {5'b11110, 3'b101, fs[7:4], 1'b0, 3'b011};
      s = {5'b01100, 3'b100, 4'b1101, fs[3:0]};
      expect_rec(1'b1, 5'b01100, 3'd4, {18'h0, fs}, {p, s}, "R7 frame size");
      put_half(p); put_half(s);

      // R9 jump, both exchange values
      tg = 26'h2B4_C1D5;
      p = {5'b00011, 1'b1, tg[20:16], tg[25:21]};
      expect_rec(1'b1, 5'b00011, 3'd5, tg, {p, tg[15:0]}, "R9 jump x=1");
      put_half(p); put_half(tg[15:0]);
      tg = 26'h1C3_7E09;
      p = {5'b00011, 1'b0, tg[20:16], tg[25:21]};
      s = {5'b11110, tg[10:0]};
      expect_rec(1'b1, 5'b00011, 3'd5, {s[15:0] == tg[15:0] ? tg : tg}, {p, tg[15:0]}, "R9 jump x=0");
      put_half(p); put_half(tg[15:0]);

      // R10 illegal followers, then idle again
      p = 16'hF123;
      s = 16'hF456;
      expect_rec(1'b1, 5'b11110, 3'd6, 26'h0, {p, s}, "R10 prefix after prefix");
      put_half(p); put_half(s);
      s = 16'h1987;
      expect_rec(1'b1, 5'b00011, 3'd6, 26'h0, {p, s}, "R10 jump after prefix");
      put_half(p); put_half(s);
      expect_rec(1'b0, 5'b01001, 3'd0, 26'h0, 32'h0000_4A23, "R10 idle after illegal");
      put_half(16'h4A23);

      // R11 back-pressure
      drain();
      @(posedge clk); #1 out_ready = 1'b0;
      expect_rec(1'b0, 5'b00101, 3'd0, 26'h0, 32'h0000_2C3C, "R11 held record");
      put_half(16'h2C3C);
      check(out_valid === 1'b1, "R11 valid while stalled", {63'h0, out_valid}, 64'h1);
      check(in_ready === 1'b0, "R11 not ready while stalled", {63'h0, in_ready}, 64'h0);
      repeat (3) @(negedge clk);
      check(out_word === 32'h0000_2C3C, "R11 word held", {32'h0, out_word}, 64'h2C3C);
      check(out_valid === 1'b1, "R11 valid held", {63'h0, out_valid}, 64'h1);
      @(posedge clk); #1 out_ready = 1'b1;
      drain();

      // R12 reset while a prefix is pending
      put_half(16'hF0F0);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid === 1'b0, "R12 no output in reset", {63'h0, out_valid}, 64'h0);
      rst = 1'b0;
      expect_rec(1'b0, 5'b01001, 3'd0, 26'h0, 32'h0000_4A23, "R12 decoded alone");
      put_half(16'h4A23);
      drain();
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R3 leftover expectations", 64'(exp_q.size()), 64'h0);

      done = 1'b1;
      finish_run();
   end
endmodule